// File: doc/BRIEF.md
# Region-Granular Cache Tag Array

This block takes the place of a per-block tag array in a large cache. Each of its entries covers one aligned memory region of several cache blocks. An entry holds the region tag and, for every block of the region, a small location field. The field is a present bit plus the number of the data-array way that holds the block. A single combinational lookup therefore answers three questions at once: whether the region is tracked, which of its blocks are resident, and in which data way each one sits.

One update port per cycle changes the structure. It can record a block fill into a data way, drop a block on eviction, allocate a new region, or invalidate a whole region. When an allocation lands in a set whose entries are all valid, a pseudo-LRU choice picks the displaced entry. That entry's tag and location fields appear on the victim outputs in the same cycle, so the surrounding cache can write back or drop the blocks it still names. The data array, per-block status bits and coherence state stay outside this block.

The geometry is parameterised. The full-size configuration is 64-byte blocks, 16 blocks per region, 2048 sets of 12 entries, a 50-bit address and 16 data ways. The elaboration default keeps 64 sets so that the register storage stays small.

Top module: `region_tag_array`

## Requirements
- R1: After rst_ni is released, every entry is invalid, every lookup misses and reports no present blocks.
- R2: The address splits, from bit 0 upward, into a block offset of BLK_W bits, a block-in-region index of RBLK_W bits, a set index of SET_W bits and the region tag in the remaining bits. A lookup reports hit, the per-block present vector (bit b for block b) and the per-block data way (field b at bits b*DWAY_W upward; absent blocks read 0) combinationally from the stored state.
- R3: An update with op 1 (fill) to a tracked region marks the addressed block present in data way upd_way_i, overwriting any earlier way.
- R4: A fill (op 1) or block eviction (op 2) whose region is not tracked raises upd_err_o in that cycle and changes no state.
- R5: A block eviction (op 2) to a tracked region clears that block's present bit, and its way then reads 0.
- R6: An allocation (op 3) of an untracked region into a set with an invalid entry uses the lowest-numbered invalid entry, starts with no present blocks and raises no victim.
- R7: An allocation of an untracked region into a full set replaces the lowest-numbered entry whose recently-used bit is clear. In the same cycle it raises vic_valid_o with that entry's tag, present vector and way fields.
- R8: An allocation (op 3) of a region that is already tracked changes nothing and raises neither a victim nor an error.
- R9: An invalidation (op 4) of a tracked region removes it so later lookups miss. An invalidation of an untracked region has no effect and no error. Op 0 does nothing.
- R10: A lookup in the same cycle as an update returns the state from before that update.
- R11: Each set keeps one recently-used bit per entry. An allocation or a fill sets the bit of the entry it touches. If that would set every bit of the set, the other bits are cleared. Evictions, invalidations and lookups leave the bits alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_hit_o | output | 1 | Region tracked |
| lk_blk_vld_o | output | BPR | Per-block present vector |
| lk_blk_way_o | output | BPR*DWAY_W | Per-block data way fields |
| upd_valid_i | input | 1 | Update request valid |
| upd_op_i | input | 3 | 0 none, 1 fill, 2 evict block, 3 allocate, 4 invalidate region |
| upd_addr_i | input | ADDR_W | Update address |
| upd_way_i | input | DWAY_W | Data way for a fill |
| upd_err_o | output | 1 | Fill or eviction to an untracked region |
| vic_valid_o | output | 1 | Allocation displaces a valid entry |
| vic_tag_o | output | TAG_W | Displaced region tag |
| vic_blk_vld_o | output | BPR | Displaced present vector |
| vic_blk_way_o | output | BPR*DWAY_W | Displaced way fields |

## Verification
The bench builds the block with a 16-bit address, 4-byte blocks, four blocks per region, four sets of four entries and four data ways. At that size a handful of region tags fills a set, so replacement, victim read-out and the all-bits-set reset of the recently-used bits happen often. A random phase drawing tags from a small pool also hits re-allocation, fills to missing regions and invalidation of absent regions. Same-cycle lookup and update on one region shows that lookups see the state from before the update.

// File: rtl/rgt_pkg.sv
package rgt_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FILL  = 3'd1,
    OP_EVICT = 3'd2,
    OP_ALLOC = 3'd3,
    OP_INVAL = 3'd4
  } rgt_op_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rgt_addr_split.sv
module rgt_addr_split #(
  parameter int ADDR_W = 50,
  parameter int BLK_W  = 6,
  parameter int RBLK_W = 4,
  parameter int SET_W  = 6,
  localparam int TAG_W = ADDR_W - BLK_W - RBLK_W - SET_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [SET_W-1:0]  set_o,
  output logic [RBLK_W-1:0] bidx_o
);
  assign bidx_o = addr_i[BLK_W +: RBLK_W];
  assign set_o  = addr_i[BLK_W+RBLK_W +: SET_W];
  assign tag_o  = addr_i[ADDR_W-1 -: TAG_W];

  logic unused_off;
  assign unused_off = ^addr_i[BLK_W-1:0];
endmodule

// File: rtl/rgt_set_match.sv
module rgt_set_match #(
  parameter int WAYS  = 12,
  parameter int TAG_W = 34,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_o = |hit_vec;

  // R2
  one_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/rgt_victim_sel.sv
module rgt_victim_sel #(
  parameter int WAYS = 12,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAYS-1:0]  mru_i,
  output logic [WAY_W-1:0] way_o,
  output logic             evict_o
);
  logic             has_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;

  always_comb begin
    free_way = '0;
    old_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) free_way = WAY_W'(w);
      if (!mru_i[w]) old_way  = WAY_W'(w);
    end
  end

  assign has_free = ~&vld_i;
  assign way_o    = has_free ? free_way : old_way;
  assign evict_o  = !has_free;

  // R6
  free_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    has_free |-> !vld_i[way_o]);
  // R7
  old_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_o |-> !mru_i[way_o]);
endmodule

// File: rtl/region_tag_array.sv
module region_tag_array
  import rgt_pkg::*;
#(
  parameter int ADDR_W = 50,
  parameter int BLK_W  = 6,
  parameter int RBLK_W = 4,
  parameter int SET_W  = 6,
  parameter int WAYS   = 12,
  parameter int DWAY_W = 4,
  localparam int BPR   = 1 << RBLK_W,
  localparam int TAG_W = ADDR_W - BLK_W - RBLK_W - SET_W,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     lk_addr_i,
  output logic                  lk_hit_o,
  output logic [BPR-1:0]        lk_blk_vld_o,
  output logic [BPR*DWAY_W-1:0] lk_blk_way_o,
  input  logic                  upd_valid_i,
  input  logic [2:0]            upd_op_i,
  input  logic [ADDR_W-1:0]     upd_addr_i,
  input  logic [DWAY_W-1:0]     upd_way_i,
  output logic                  upd_err_o,
  output logic                  vic_valid_o,
  output logic [TAG_W-1:0]      vic_tag_o,
  output logic [BPR-1:0]        vic_blk_vld_o,
  output logic [BPR*DWAY_W-1:0] vic_blk_way_o
);
  // storage
  logic [WAYS-1:0]       vld_q [SETS];
  logic [WAYS-1:0]       mru_q [SETS];
  logic [TAG_W-1:0]      tag_q [SETS][WAYS];
  logic [BPR-1:0]        bv_q  [SETS][WAYS];
  logic [BPR*DWAY_W-1:0] bw_q  [SETS][WAYS];

  // lookup path
  logic [TAG_W-1:0]  l_tag;
  logic [SET_W-1:0]  l_set;
  logic [RBLK_W-1:0] l_bidx;
  logic              l_hit;
  logic [WAY_W-1:0]  l_way;
  logic [WAYS-1:0][TAG_W-1:0] l_tags;

  rgt_addr_split #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .RBLK_W(RBLK_W), .SET_W(SET_W)) u_lk_split (
    .addr_i(lk_addr_i), .tag_o(l_tag), .set_o(l_set), .bidx_o(l_bidx)
  );

  always_comb begin
    for (int w = 0; w < WAYS; w++) l_tags[w] = tag_q[l_set][w];
  end

  rgt_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .tags_i(l_tags), .vld_i(vld_q[l_set]),
    .tag_i(l_tag), .hit_o(l_hit), .way_o(l_way)
  );

  assign lk_hit_o     = l_hit;
  assign lk_blk_vld_o = l_hit ? bv_q[l_set][l_way] : '0;

  for (genvar b = 0; b < BPR; b++) begin : g_lk_way
    assign lk_blk_way_o[b*DWAY_W +: DWAY_W] =
      lk_blk_vld_o[b] ? bw_q[l_set][l_way][b*DWAY_W +: DWAY_W] : '0;
  end

  logic unused_lbidx;
  assign unused_lbidx = ^l_bidx;

  // update path
  logic [TAG_W-1:0]  u_tag;
  logic [SET_W-1:0]  u_set;
  logic [RBLK_W-1:0] u_bidx;
  logic              u_hit;
  logic [WAY_W-1:0]  u_way;
  logic [WAYS-1:0][TAG_W-1:0] u_tags;
  logic [WAY_W-1:0]  v_way;
  logic              v_evict;
  rgt_op_e           op;

  rgt_addr_split #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .RBLK_W(RBLK_W), .SET_W(SET_W)) u_up_split (
    .addr_i(upd_addr_i), .tag_o(u_tag), .set_o(u_set), .bidx_o(u_bidx)
  );

  always_comb begin
    for (int w = 0; w < WAYS; w++) u_tags[w] = tag_q[u_set][w];
  end

  rgt_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .tags_i(u_tags), .vld_i(vld_q[u_set]),
    .tag_i(u_tag), .hit_o(u_hit), .way_o(u_way)
  );

  rgt_victim_sel #(.WAYS(WAYS)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_q[u_set]), .mru_i(mru_q[u_set]),
    .way_o(v_way), .evict_o(v_evict)
  );

  assign op = rgt_op_e'(upd_op_i);

  logic fill_ok, evict_ok, alloc_new, alloc_hit, inval_ok;
  assign fill_ok   = upd_valid_i && (op == OP_FILL)  && u_hit;
  assign evict_ok  = upd_valid_i && (op == OP_EVICT) && u_hit;
  assign alloc_new = upd_valid_i && (op == OP_ALLOC) && !u_hit;
  assign alloc_hit = upd_valid_i && (op == OP_ALLOC) && u_hit;
  assign inval_ok  = upd_valid_i && (op == OP_INVAL) && u_hit;
  assign upd_err_o = upd_valid_i && ((op == OP_FILL) || (op == OP_EVICT)) && !u_hit;

  assign vic_valid_o   = alloc_new && v_evict;
  assign vic_tag_o     = tag_q[u_set][v_way];
  assign vic_blk_vld_o = bv_q[u_set][v_way];
  assign vic_blk_way_o = bw_q[u_set][v_way];

  function automatic logic [WAYS-1:0] mru_touch(input logic [WAYS-1:0] cur, input logic [WAY_W-1:0] w);
    logic [WAYS-1:0] sel, nxt;
    sel = '0;
    sel[w] = 1'b1;
    nxt = cur | sel;
    return (&nxt) ? sel : nxt;
  endfunction

  // valid and recency state: reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        mru_q[s] <= '0;
      end
    end else begin
      if (alloc_new) begin
        vld_q[u_set][v_way] <= 1'b1;
        mru_q[u_set]        <= mru_touch(mru_q[u_set], v_way);
      end
      if (fill_ok)  mru_q[u_set] <= mru_touch(mru_q[u_set], u_way);
      if (inval_ok) vld_q[u_set][u_way] <= 1'b0;
    end
  end

  // payload: gated by valid, no reset needed
  always_ff @(posedge clk_i) begin
    if (alloc_new) begin
      tag_q[u_set][v_way] <= u_tag;
      bv_q[u_set][v_way]  <= '0;
      bw_q[u_set][v_way]  <= '0;
    end
    if (fill_ok) begin
      bv_q[u_set][u_way][u_bidx] <= 1'b1;
      bw_q[u_set][u_way][u_bidx*DWAY_W +: DWAY_W] <= upd_way_i;
    end
    if (evict_ok) begin
      bv_q[u_set][u_way][u_bidx] <= 1'b0;
      bw_q[u_set][u_way][u_bidx*DWAY_W +: DWAY_W] <= '0;
    end
  end

  // R3
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ok |=> bv_q[$past(u_set)][$past(u_way)][$past(u_bidx)]);
  // R5
  evict_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_ok |=> !bv_q[$past(u_set)][$past(u_way)][$past(u_bidx)]);
  // R8
  alloc_hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_hit |-> !vic_valid_o && !upd_err_o);
  // R9
  inval_gone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_ok |=> !vld_q[$past(u_set)][$past(u_way)]);
  // R11
  mru_not_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_new || fill_ok) |=> ($countones(mru_q[$past(u_set)]) < WAYS));
endmodule

// File: tb/region_tag_array_tb.sv
module region_tag_array_tb;
  localparam int ADDR_W = 16, BLK_W = 2, RBLK_W = 2, SET_W = 2, WAYS = 4, DWAY_W = 2;
  localparam int BPR = 4, TAG_W = 10, NS = 4;

  logic clk = 0, rst_ni = 0;
  logic [ADDR_W-1:0] lk_addr_i = '0, upd_addr_i = '0;
  logic lk_hit_o, upd_valid_i = 0, upd_err_o, vic_valid_o;
  logic [BPR-1:0] lk_blk_vld_o, vic_blk_vld_o;
  logic [BPR*DWAY_W-1:0] lk_blk_way_o, vic_blk_way_o;
  logic [2:0] upd_op_i = '0;
  logic [DWAY_W-1:0] upd_way_i = '0;
  logic [TAG_W-1:0] vic_tag_o;

  always #2.5 clk = ~clk;

  region_tag_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .RBLK_W(RBLK_W), .SET_W(SET_W),
                     .WAYS(WAYS), .DWAY_W(DWAY_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lk_addr_i(lk_addr_i), .lk_hit_o(lk_hit_o),
    .lk_blk_vld_o(lk_blk_vld_o), .lk_blk_way_o(lk_blk_way_o), .upd_valid_i(upd_valid_i),
    .upd_op_i(upd_op_i), .upd_addr_i(upd_addr_i), .upd_way_i(upd_way_i), .upd_err_o(upd_err_o),
    .vic_valid_o(vic_valid_o), .vic_tag_o(vic_tag_o), .vic_blk_vld_o(vic_blk_vld_o),
    .vic_blk_way_o(vic_blk_way_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model
  bit             m_vld [NS][WAYS];
  int             m_tag [NS][WAYS];
  bit [BPR-1:0]   m_bv  [NS][WAYS];
  int             m_bw  [NS][WAYS][BPR];
  bit [WAYS-1:0]  m_mru [NS];

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int blk);
    return ADDR_W'((tag << 6) | (set << 4) | (blk << 2) | (tag & 3));
  endfunction

  function automatic int m_find(input int tag, input int set);
    for (int w = 0; w < WAYS; w++) if (m_vld[set][w] && m_tag[set][w] == tag) return w;
    return -1;
  endfunction

  function automatic logic [BPR*DWAY_W-1:0] m_ways(input int set, input int w);
    logic [BPR*DWAY_W-1:0] r = '0;
    for (int b = 0; b < BPR; b++) if (m_bv[set][w][b]) r[b*DWAY_W +: DWAY_W] = DWAY_W'(m_bw[set][w][b]);
    return r;
  endfunction

  function automatic void m_touch(input int set, input int w);
    bit [WAYS-1:0] n = m_mru[set];
    n[w] = 1;
    if (n == '1) begin n = '0; n[w] = 1; end
    m_mru[set] = n;
  endfunction

  task automatic chk(input string ctx, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", ctx, what, act, exp);
    end
  endtask

  task automatic step(input string ctx, input bit uv, input int op, input logic [ADDR_W-1:0] ua,
                      input int uw, input logic [ADDR_W-1:0] la);
    int lt, ls, lw, ut, us, ub, uh, vw;
    bit free, eerr, anew;
    @(negedge clk);
    upd_valid_i = uv; upd_op_i = 3'(op); upd_addr_i = ua; upd_way_i = DWAY_W'(uw); lk_addr_i = la;
    #1;
    lt = int'(la[15:6]); ls = int'(la[5:4]);
    lw = m_find(lt, ls);
    chk(ctx, "R2 lk_hit", lk_hit_o, lw >= 0);
    chk(ctx, "R2 lk_blk_vld", lk_blk_vld_o, (lw >= 0) ? m_bv[ls][lw] : 0);
    chk(ctx, "R2 lk_blk_way", lk_blk_way_o, (lw >= 0) ? m_ways(ls, lw) : 0);
    ut = int'(ua[15:6]); us = int'(ua[5:4]); ub = int'(ua[3:2]);
    uh = m_find(ut, us);
    eerr = uv && (op == 1 || op == 2) && uh < 0;
    anew = uv && op == 3 && uh < 0;
    chk(ctx, "R4 err", upd_err_o, eerr);
    free = 0; vw = 0;
    for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[us][w]) begin free = 1; vw = w; end
    if (!free) for (int w = WAYS - 1; w >= 0; w--) if (!m_mru[us][w]) vw = w;
    chk(ctx, "R7 vic_valid", vic_valid_o, anew && !free);
    if (anew && !free) begin
      chk(ctx, "R7 vic_tag", vic_tag_o, m_tag[us][vw]);
      chk(ctx, "R7 vic_blk_vld", vic_blk_vld_o, m_bv[us][vw]);
      chk(ctx, "R7 vic_blk_way", vic_blk_way_o, m_ways(us, vw));
    end
    @(posedge clk);
    if (uv) begin
      case (op)
        1: if (uh >= 0) begin m_bv[us][uh][ub] = 1; m_bw[us][uh][ub] = uw; m_touch(us, uh); end
        2: if (uh >= 0) begin m_bv[us][uh][ub] = 0; m_bw[us][uh][ub] = 0; end
        3: if (anew) begin
             m_vld[us][vw] = 1; m_tag[us][vw] = ut; m_bv[us][vw] = '0;
             for (int b = 0; b < BPR; b++) m_bw[us][vw][b] = 0;
             m_touch(us, vw);
           end
        4: if (uh >= 0) m_vld[us][uh] = 0;
        default: ;
      endcase
    end
  endtask

  task automatic look(input string ctx, input logic [ADDR_W-1:0] la);
    step(ctx, 0, 0, '0, 0, la);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_mru[s] = '0;
      for (int w = 0; w < WAYS; w++) m_vld[s][w] = 0;
    end
    repeat (3) @(posedge clk);
    rst_ni = 1;
    look("R1 reset", mk(1, 1, 0));
    look("R1 reset", mk(0, 0, 0));
    step("R9 op0 no effect", 1, 0, mk(1, 1, 0), 0, mk(1, 1, 0));
    // R6 and R10: allocate four regions, lookup same region same cycle
    for (int t = 1; t <= 4; t++) step("R6 R10 alloc free", 1, 3, mk(t, 1, 0), 0, mk(t, 1, 0));
    look("R6 lookup new", mk(3, 1, 1));
    step("R3 fill", 1, 1, mk(1, 1, 0), 3, mk(1, 1, 0));
    step("R3 fill", 1, 1, mk(1, 1, 2), 1, mk(1, 1, 0));
    step("R3 refill", 1, 1, mk(1, 1, 2), 2, mk(1, 1, 2));
    look("R3 after fill", mk(1, 1, 3));
    step("R4 fill absent", 1, 1, mk(9, 1, 0), 1, mk(9, 1, 0));
    step("R4 evict absent", 1, 2, mk(9, 2, 0), 0, mk(9, 1, 0));
    step("R5 evict", 1, 2, mk(1, 1, 0), 0, mk(1, 1, 0));
    look("R5 after evict", mk(1, 1, 0));
    step("R8 realloc", 1, 3, mk(1, 1, 0), 0, mk(1, 1, 0));
    look("R8 after realloc", mk(1, 1, 0));
    step("R7 victim", 1, 3, mk(5, 1, 0), 0, mk(2, 1, 0));
    step("R11 fill touch", 1, 1, mk(3, 1, 3), 0, mk(3, 1, 0));
    step("R7 R11 victim", 1, 3, mk(6, 1, 0), 0, mk(6, 1, 0));
    step("R7 victim again", 1, 3, mk(7, 1, 0), 0, mk(1, 1, 0));
    step("R9 inval", 1, 4, mk(5, 1, 0), 0, mk(5, 1, 0));
    look("R9 after inval", mk(5, 1, 0));
    step("R9 inval absent", 1, 4, mk(11, 1, 0), 0, mk(3, 1, 0));
    step("R6 refill hole", 1, 3, mk(12, 1, 0), 0, mk(12, 1, 0));
    for (int i = 0; i < 800; i++) begin
      int op, tg, st, bk;
      op = (i % 7 == 0) ? 4 : int'($urandom_range(0, 3));
      tg = int'($urandom_range(0, 6)); st = int'($urandom_range(0, 1)); bk = int'($urandom_range(0, 3));
      step("R2 random", 1, op, mk(tg, st, bk), int'($urandom_range(0, 3)),
           mk(int'($urandom_range(0, 6)), int'($urandom_range(0, 1)), int'($urandom_range(0, 3))));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule